// File: doc/BRIEF.md
# Dual-Mode Pulse Accumulator Counter

This block is an 8-bit up-counter driven by one external input pin. In event mode it adds one for each active edge on the pin; in gated mode it adds one per tick of a free-running internal divider, but only while the pin sits at its active level. The pin always passes through a two-flop synchronizer before it is used. One control bit picks the mode. A second control bit picks the polarity: the rising edge or the high level when clear, the falling edge or the low level when set. A third control bit enables counting.

Software reaches the block through a small register bus with three word addresses. The count is at address 0 and can be read or written at any time. Control is at address 1: bit 0 enables counting, bit 1 selects gated mode, and bit 2 selects the inverted polarity. The flags are at address 2: bit 0 is overflow and bit 1 is the input-edge flag. Both flags also drive output pins, so an interrupt controller can use them directly.

Top module: `pulse_acc`

## Requirements
- R1: After reset the count, the control register and both flags read as zero.
- R2: With control bit 1 clear and control bit 0 set, each rising pin edge (control bit 2 clear) or each falling pin edge (control bit 2 set) adds exactly one to the count.
- R3: In event mode, a pin that toggles on every clock cycle (one cycle high, one cycle low) has every one of its active edges counted.
- R4: With control bit 1 set, the count adds one per GATE_DIV clock cycles while the synchronized pin is at its active level (high when control bit 2 is clear, low when it is set), and does not change while the pin is inactive.
- R5: While control bit 0 is clear the count holds its value, whatever the pin does, and it can still be read and written.
- R6: A bus write to address 0 loads the written value exactly, even when an increment falls in the same cycle, and that write never sets the overflow flag.
- R7: An increment that takes the count from 0xFF to 0x00 sets the sticky overflow flag (address 2 bit 0, pin ovf_flag). Writing 1 to that bit clears it, and writing 0 leaves it set.
- R8: The sticky input-edge flag (address 2 bit 1, pin edge_flag) is set by each counted edge in event mode, and by the trailing edge of the gate in gated mode. Writing 1 to that bit clears it, and writing 1 only to bit 0 leaves it set.
- R9: A pin edge is reflected in the count after the third rising clock edge following the pin change, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | External event or gate input, asynchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 count, 1 control, 2 flags |
| wdata | input | W | Write data |
| rdata | output | W | Combinational read data for addr |
| ovf_flag | output | 1 | Sticky overflow flag |
| edge_flag | output | 1 | Sticky input-edge flag |

## Verification
Event mode is exercised with pulses of several widths on both polarities. This separates counting on the correct edge from counting on both edges or on the wrong one. It also shows, at one-cycle toggling, that the synchronizer loses no edge. Gated mode is run with active-high and active-low gates held for whole multiples of the divider period, so an exact count exposes a wrong gate level or a wrong tick rate. Runs that start near 0xFF separate a correct wrap and flag from a missed or early overflow. Back-to-back writes during gated counting cover every divider phase, so a lost write priority shows up as an off-by-one value.

// File: rtl/pulse_acc.sv
`timescale 1ns/1ps
module pulse_acc #(
  parameter int W        = 8,
  parameter int GATE_DIV = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pin_in,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         ovf_flag,
  output logic         edge_flag
);
  localparam int DW = (GATE_DIV > 1) ? $clog2(GATE_DIV) : 1;

  logic [2:0]    sync_q;
  logic [W-1:0]  count_q;
  logic [2:0]    ctrl_q;
  logic [DW-1:0] div_q;

  logic en, gated, pol;
  logic rise, fall, act_edge, trail_edge, gate_on, tick, inc, wrap;
  logic wr_cnt, wr_ctl, wr_flg, edge_set;

  assign en    = ctrl_q[0];
  assign gated = ctrl_q[1];
  assign pol   = ctrl_q[2];

  assign rise       = sync_q[1] & ~sync_q[2];
  assign fall       = ~sync_q[1] & sync_q[2];
  assign act_edge   = pol ? fall : rise;
  assign trail_edge = pol ? rise : fall;
  assign gate_on    = sync_q[1] ^ pol;
  assign tick       = (div_q == DW'(GATE_DIV - 1));

  assign wr_cnt = wr_en && (addr == 2'd0);
  assign wr_ctl = wr_en && (addr == 2'd1);
  assign wr_flg = wr_en && (addr == 2'd2);

  assign inc      = en & (gated ? (gate_on & tick) : act_edge);
  assign wrap     = inc & (&count_q) & ~wr_cnt;
  assign edge_set = en & (gated ? trail_edge : act_edge);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], pin_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    div_q <= '0;
    else if (tick) div_q <= '0;
    else           div_q <= div_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      count_q <= '0;
    else if (wr_cnt) count_q <= wdata;
    else if (inc)    count_q <= count_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ctrl_q <= '0;
    else if (wr_ctl) ctrl_q <= wdata[2:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     ovf_flag <= 1'b0;
    else if (wrap)                  ovf_flag <= 1'b1;
    else if (wr_flg && wdata[0])    ovf_flag <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     edge_flag <= 1'b0;
    else if (edge_set)              edge_flag <= 1'b1;
    else if (wr_flg && wdata[1])    edge_flag <= 1'b0;

  always_comb begin
    case (addr)
      2'd0:    rdata = count_q;
      2'd1:    rdata = W'(ctrl_q);
      2'd2:    rdata = W'({edge_flag, ovf_flag});
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/pulse_acc_chk.sv
`timescale 1ns/1ps
module pulse_acc_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [1:0]   addr,
  input logic [W-1:0] wdata,
  input logic [W-1:0] count_q,
  input logic         ctrl_en,
  input logic         gated,
  input logic         gate_on,
  input logic         ovf_flag,
  input logic         edge_flag
);
  logic cwr;
  assign cwr = wr_en && (addr == 2'd0);

  a_r6_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    cwr |=> (count_q == $past(wdata)));

  a_r5_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && !cwr) |=> $stable(count_q));

  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !cwr |=> (count_q == $past(count_q) || count_q == $past(count_q) + {{(W-1){1'b0}}, 1'b1}));

  a_r7_wrap_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (!cwr && (&count_q)) |=> (count_q != '0 || ovf_flag));

  a_r4_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && gated && !gate_on && !cwr) |=> $stable(count_q));

  a_r8_edge_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(edge_flag) |-> $past(ctrl_en));
endmodule

bind pulse_acc pulse_acc_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .count_q(count_q), .ctrl_en(ctrl_q[0]), .gated(ctrl_q[1]), .gate_on(gate_on),
  .ovf_flag(ovf_flag), .edge_flag(edge_flag)
);

// File: tb/pulse_acc_tb_top.sv
`timescale 1ns/1ps
module pulse_acc_tb_top;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_in = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       ovf_flag, edge_flag;

  int tests = 0;
  int fails = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  pulse_acc #(.W(8), .GATE_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ovf_flag(ovf_flag), .edge_flag(edge_flag)
  );

  typedef struct packed {
    logic       gmode;
    logic       pol;
    logic [3:0] hw;
    logic [7:0] n;
    logic [7:0] start;
    logic [7:0] expc;
    logic       xovf;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 4'd2, 8'd5, 8'h10, 8'h15, 1'b0},
    '{1'b0, 1'b1, 4'd3, 8'd7, 8'h00, 8'h07, 1'b0},
    '{1'b0, 1'b0, 4'd1, 8'd9, 8'h40, 8'h49, 1'b0},
    '{1'b0, 1'b0, 4'd2, 8'd3, 8'hFE, 8'h01, 1'b1},
    '{1'b1, 1'b0, 4'd0, 8'd6, 8'h20, 8'h26, 1'b0},
    '{1'b1, 1'b1, 4'd0, 8'd3, 8'hFE, 8'h01, 1'b1},
    '{1'b0, 1'b1, 4'd1, 8'd4, 8'h80, 8'h84, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic pol, input int hw);
    pin_in = ~pol;
    idle(hw);
    pin_in = pol;
    idle(hw);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    rd(2'd0, v); chk("R1 count", v, 8'h00);
    rd(2'd1, v); chk("R1 ctrl", v, 8'h00);
    rd(2'd2, v); chk("R1 flags", v, 8'h00);

    for (int i = 0; i < NV; i++) begin
      wr(2'd1, 8'h00);
      pin_in = VECS[i].pol;
      idle(5);
      wr(2'd2, 8'h03);
      wr(2'd0, VECS[i].start);
      wr(2'd1, {5'b0, VECS[i].pol, VECS[i].gmode, 1'b1});
      if (VECS[i].gmode) begin
        pin_in = ~VECS[i].pol;
        idle(int'(VECS[i].n) * DIV);
        pin_in = VECS[i].pol;
      end else begin
        for (int k = 0; k < int'(VECS[i].n); k++) pulse(VECS[i].pol, int'(VECS[i].hw));
      end
      idle(6);
      rd(2'd0, v);
      chk(VECS[i].gmode ? "R4 gated count" : (VECS[i].hw == 4'd1 ? "R3 fast count" : "R2 edge count"),
          v, VECS[i].expc);
      chk("R7 overflow pin", {7'b0, ovf_flag}, {7'b0, VECS[i].xovf});
      chk("R8 edge flag pin", {7'b0, edge_flag}, 8'h01);
      if (VECS[i].xovf) begin
        wr(2'd2, 8'h00);
        chk("R7 write zero keeps", {7'b0, ovf_flag}, 8'h01);
        wr(2'd2, 8'h01);
        chk("R7 write one clears", {7'b0, ovf_flag}, 8'h00);
      end
    end

    // R9 latency and R8 clear behaviour
    wr(2'd1, 8'h00);
    pin_in = 1'b0;
    idle(5);
    wr(2'd2, 8'h03);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h01);
    pin_in = 1'b1;
    idle(2);
    rd(2'd0, v); chk("R9 not after two edges", v, 8'h00);
    idle(1);
    rd(2'd0, v); chk("R9 after three edges", v, 8'h01);
    chk("R8 set by counted edge", {7'b0, edge_flag}, 8'h01);
    wr(2'd2, 8'h01);
    chk("R8 other bit keeps", {7'b0, edge_flag}, 8'h01);
    wr(2'd2, 8'h02);
    chk("R8 write one clears", {7'b0, edge_flag}, 8'h00);

    // R5 disabled hold
    wr(2'd1, 8'h00);
    pin_in = 1'b0;
    for (int k = 0; k < 4; k++) pulse(1'b0, 2);
    idle(5);
    rd(2'd0, v); chk("R5 hold while disabled", v, 8'h01);
    chk("R5 no edge flag", {7'b0, edge_flag}, 8'h00);
    wr(2'd0, 8'h33);
    rd(2'd0, v); chk("R5 write while disabled", v, 8'h33);

    // R6 write priority against every divider phase
    wr(2'd2, 8'h03);
    wr(2'd1, 8'h03);
    pin_in = 1'b1;
    idle(4);
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd0; wdata = 8'h55;
    for (int k = 0; k < 2 * DIV; k++) begin
      @(negedge clk);
      #1 chk("R6 exact load", rdata, 8'h55);
    end
    wdata = 8'hFF;
    for (int k = 0; k < 2 * DIV; k++) begin
      @(negedge clk);
      #1 chk("R6 load FF", rdata, 8'hFF);
      chk("R6 no overflow on write", {7'b0, ovf_flag}, 8'h00);
    end
    wr_en = 1'b0;
    idle(DIV + 1);
    chk("R7 wrap after release", {7'b0, ovf_flag}, 8'h01);

    done = 1'b1;
    finish_run();
  end
endmodule